// File: doc/BRIEF.md
# Daisy-Chain Dual-Channel DAC Frame Sender

This block is the host side of a chain of dual-channel serial DACs. All the converters share one serial clock and one select/load line. Serial data leaves the host, passes through each converter's shift register in turn, and comes back to the host on a return line. Software-facing logic writes one 12-bit code per channel into a small slot buffer with `wrEn`/`wrAddr`/`wrData`, then pulses `start`. The block copies the buffer into a frame of 24 bits per device and lowers the select line while the serial clock is low. It shifts the whole frame out, waits, and raises the select line once. That single rising edge makes every converter in the chain take its new codes at the same moment. A one-cycle `done` pulse closes the transfer.

The serial clock half-period is set at run time in system clock cycles. The bits that come back on the return line are captured at each serial rising edge. After a transfer, the capture register holds the contents the chain had before that transfer.

Top module: `dac_chain_host`

## Requirements
- R1: After reset, `csLd` is high, `sclk` is low, `busy` and `done` are low, and `rdData` is zero.
- R2: Slot address `2*d + c` holds device `d`, channel `c` (c=0 is channel A, c=1 is channel B). Device 0 is the converter wired to `sdo`. The frame sends device NUM_DEV-1 first and device 0 last, so after the load edge each device holds its own two codes.
- R3: Within each device's 24 bits, channel A's code comes before channel B's, and each code goes out MSB first. One transfer makes exactly 24×NUM_DEV rising `sclk` edges while `csLd` is low.
- R4: `sclk` is low whenever `csLd` falls, and it stays low for one half-period before the first rising edge. `sclk` is never high while `csLd` is high.
- R5: `sdo` changes only while `sclk` is low. It is stable through every high phase of `sclk`.
- R6: Every high phase and every low phase of `sclk` while `csLd` is low lasts exactly H system cycles. H is `halfPeriod`, except that a value of 0 counts as 1.
- R7: After the last falling `sclk` edge, `sclk` stays low for H cycles. Then `csLd` rises exactly once per transfer.
- R8: `done` is a one-cycle pulse that comes H cycles after `csLd` rises. `busy` is high from the cycle after an accepted `start` through the `done` cycle, and it is low in the cycle after that.
- R9: A `start` pulse while `busy` is high is ignored. It produces no second select-low period and no second `done`.
- R10: Each rising `sclk` edge shifts the level of `sdi` into `rdData` at bit 0. The first bit returned ends up in the MSB. After a transfer through a 24×NUM_DEV-bit chain, `rdData` equals the frame the previous transfer sent.
- R11: Buffer writes made while a transfer runs do not change the bits in flight. They go out with the next transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| wrEn | input | 1 | Slot buffer write enable |
| wrAddr | input | $clog2(2*NUM_DEV) | Slot index, 2*device + channel |
| wrData | input | CODE_W | Channel code |
| halfPeriod | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| sdi | input | 1 | Return data from the chain's last device |
| sclk | output | 1 | Shared serial clock |
| csLd | output | 1 | Shared select (low) and load (rising edge) line |
| sdo | output | 1 | Serial data into device 0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdData | output | 2*CODE_W*NUM_DEV | Captured return bits |

## Verification
The bench sweeps six code patterns across four half-period settings: all zeros, all ones, a walking single bit, alternating 0xAAA/0x555, distinct ascending codes per slot, and a single bit moving right. All-zero and all-one frames expose stuck data and dropped or extra edges. The walking and alternating patterns show whether bit order within a code, or channel A against channel B, has been swapped. Distinct per-slot codes reveal a reversed device order in the chain. A behavioural model of the converter chain checks which codes each device latches and what the return line hands back. A further transfer takes a second `start` and a slot write in mid-flight, which shows that the busy guard and the frame snapshot work.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_LOAD,
    ST_DONE
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadFrame;  // snapshot the slot buffer into the shifter
    logic csAssert;   // drive select low
    logic csRelease;  // drive select high (load edge)
    logic clkRise;    // serial clock goes high, capture return bit
    logic clkFall;    // serial clock goes low, advance data
  } dpStrobe_t;

endpackage

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dac_chain_pkg::*;
#(
  parameter int TOTAL_BITS = 48,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] halfPeriod,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = $clog2(TOTAL_BITS + 1);

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] hpEff;
  logic [CNT_W-1:0] bitCnt;
  logic             clkHigh;
  logic             tick;
  logic             lastBit;

  assign hpEff   = (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
  assign tick    = (divCnt >= hpEff - DIV_W'(1));
  assign lastBit = (bitCnt == CNT_W'(TOTAL_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      clkHigh <= 1'b0;
    end else begin
      if (state == ST_IDLE || tick) divCnt <= '0;
      else                          divCnt <= divCnt + DIV_W'(1);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SETUP;
            bitCnt  <= '0;
            clkHigh <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state   <= ST_SHIFT;
            clkHigh <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (clkHigh) begin
              clkHigh <= 1'b0;
              if (lastBit) state <= ST_HOLD;
              else         bitCnt <= bitCnt + CNT_W'(1);
            end else begin
              clkHigh <= 1'b1;
            end
          end
        end
        ST_HOLD: if (tick) state <= ST_LOAD;
        ST_LOAD: if (tick) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadFrame = (state == ST_IDLE) && start;
    strobe.csAssert  = (state == ST_IDLE) && start;
    strobe.clkRise   = tick && ((state == ST_SETUP) || ((state == ST_SHIFT) && !clkHigh));
    strobe.clkFall   = tick && (state == ST_SHIFT) && clkHigh;
    strobe.csRelease = tick && (state == ST_HOLD);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/dac_chain_dp.sv
module dac_chain_dp
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int CODE_W   = 12,
  parameter bit READBACK = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dpStrobe_t                              strobe,
  input  logic                                   wrEn,
  input  logic [$clog2(2*NUM_DEV)-1:0]           wrAddr,
  input  logic [CODE_W-1:0]                      wrData,
  input  logic                                   sdi,
  output logic                                   sclk,
  output logic                                   csLd,
  output logic                                   sdo,
  output logic [2*CODE_W*NUM_DEV-1:0]            rdData
);

  localparam int SLOT_N   = 2 * NUM_DEV;
  localparam int DEV_BITS = 2 * CODE_W;
  localparam int TOTAL    = DEV_BITS * NUM_DEV;

  logic [CODE_W-1:0] slotMem [SLOT_N];
  logic [TOTAL-1:0]  frameVec;
  logic [TOTAL-1:0]  shiftR;
  logic              sclkR;
  logic              csLdR;

  // Slot buffer: independent of transfers, snapshot taken at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOT_N; i++) slotMem[i] <= '0;
    end else if (wrEn && (int'(wrAddr) < SLOT_N)) begin
      slotMem[wrAddr] <= wrData;
    end
  end

  // Device 0 sits at the low end so it is shifted out last
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_frame
    assign frameVec[d*DEV_BITS +: DEV_BITS] = {slotMem[2*d], slotMem[2*d+1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftR <= '0;
      sclkR  <= 1'b0;
      csLdR  <= 1'b1;
    end else begin
      if (strobe.loadFrame) shiftR <= frameVec;
      else if (strobe.clkFall) shiftR <= {shiftR[TOTAL-2:0], 1'b0};
      if (strobe.clkRise)      sclkR <= 1'b1;
      else if (strobe.clkFall) sclkR <= 1'b0;
      if (strobe.csAssert)       csLdR <= 1'b0;
      else if (strobe.csRelease) csLdR <= 1'b1;
    end
  end

  if (READBACK) begin : g_rb
    logic [TOTAL-1:0] rdR;
    always_ff @(posedge clk) begin
      if (!rstN)               rdR <= '0;
      else if (strobe.clkRise) rdR <= {rdR[TOTAL-2:0], sdi};
    end
    assign rdData = rdR;
  end else begin : g_norb
    assign rdData = '0;
  end

  assign sclk = sclkR;
  assign csLd = csLdR;
  assign sdo  = shiftR[TOTAL-1];

endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int CODE_W   = 12,
  parameter int DIV_W    = 8,
  parameter bit READBACK = 1'b1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic                              wrEn,
  input  logic [$clog2(2*NUM_DEV)-1:0]      wrAddr,
  input  logic [CODE_W-1:0]                 wrData,
  input  logic [DIV_W-1:0]                  halfPeriod,
  input  logic                              sdi,
  output logic                              sclk,
  output logic                              csLd,
  output logic                              sdo,
  output logic                              busy,
  output logic                              done,
  output logic [2*CODE_W*NUM_DEV-1:0]       rdData
);

  localparam int TOTAL_BITS = 2 * CODE_W * NUM_DEV;

  dpStrobe_t strobe;

  dac_chain_ctrl #(
    .TOTAL_BITS(TOTAL_BITS),
    .DIV_W     (DIV_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .halfPeriod(halfPeriod),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  dac_chain_dp #(
    .NUM_DEV (NUM_DEV),
    .CODE_W  (CODE_W),
    .READBACK(READBACK)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .sdi   (sdi),
    .sclk  (sclk),
    .csLd  (csLd),
    .sdo   (sdo),
    .rdData(rdData)
  );

endmodule

// File: rtl/dac_chain_chk.sv
module dac_chain_chk #(
  parameter int TOTAL_BITS = 48
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sclk,
  input logic csLd,
  input logic sdo,
  input logic busy,
  input logic done
);

  localparam int RC_W = $clog2(TOTAL_BITS + 2);

  logic [RC_W-1:0] riseCnt;
  logic            sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseCnt  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (csLd)                  riseCnt <= '0;
      else if (sclk && !sclkPrev) riseCnt <= riseCnt + RC_W'(1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csLd && !sclk));

  p_rise_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csLd) |-> (riseCnt == RC_W'(TOTAL_BITS)));

  p_cs_fall_clk_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csLd) |-> !sclk);

  p_clk_only_selected_r4: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csLd);

  p_sdo_stable_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdo));

  p_load_clk_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csLd) |-> (!sclk && !$past(sclk)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && csLd));

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_start_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !csLd));

endmodule

bind dac_chain_host dac_chain_chk #(
  .TOTAL_BITS(TOTAL_BITS)
) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .sclk (sclk),
  .csLd (csLd),
  .sdo  (sdo),
  .busy (busy),
  .done (done)
);

// File: tb/dac_chain_host_tb.sv
module dac_chain_host_tb;

  localparam int CLK_P   = 10;
  localparam int NUM_DEV = 2;
  localparam int CODE_W  = 12;
  localparam int DIV_W   = 8;
  localparam int SLOTS   = 2 * NUM_DEV;
  localparam int DEVB    = 2 * CODE_W;
  localparam int TOT     = DEVB * NUM_DEV;
  localparam int AW      = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [CODE_W-1:0] wrData = '0;
  logic [DIV_W-1:0] halfPeriod = '0;
  logic sdi;
  logic sclk, csLd, sdo, busy, done;
  logic [TOT-1:0] rdData;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  dac_chain_host #(
    .NUM_DEV(NUM_DEV), .CODE_W(CODE_W), .DIV_W(DIV_W), .READBACK(1'b1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .halfPeriod(halfPeriod), .sdi(sdi), .sclk(sclk),
    .csLd(csLd), .sdo(sdo), .busy(busy), .done(done), .rdData(rdData)
  );

  // Behavioural chain of converters: device 0 nearest the host
  logic [TOT-1:0] chainSr = '0;
  logic [CODE_W-1:0] dacA [NUM_DEV];
  logic [CODE_W-1:0] dacB [NUM_DEV];
  assign sdi = chainSr[TOT-1];

  always @(posedge sclk) if (!csLd) chainSr <= {chainSr[TOT-2:0], sdo};
  always @(posedge csLd)
    for (int d = 0; d < NUM_DEV; d++) begin
      dacA[d] <= chainSr[d*DEVB + CODE_W +: CODE_W];
      dacB[d] <= chainSr[d*DEVB +: CODE_W];
    end

  // Waveform monitor, sampled on the falling system edge
  int cyc = 0, runLen = 0, rises = 0, csFalls = 0, dones = 0;
  int phaseErr = 0, sdoErr = 0, csClkErr = 0, csRiseCyc = 0, doneDelay = 0;
  int hpExp = 1;
  logic pSclk = 1'b0, pCs = 1'b1, pSdo = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (sclk != pSclk || csLd != pCs) begin
        if (!pCs && runLen != hpExp) phaseErr++;
        runLen = 1;
      end else begin
        runLen++;
      end
      if (sclk && !pSclk && !csLd) rises++;
      if (!csLd && pCs) begin
        csFalls++;
        if (sclk || pSclk) csClkErr++;
      end
      if (sclk && csLd) csClkErr++;
      if (sclk && pSclk && sdo != pSdo) sdoErr++;
      if (csLd && !pCs) csRiseCyc = cyc;
      if (done) begin
        dones++;
        doneDelay = cyc - csRiseCyc;
      end
    end
    pSclk = sclk; pCs = csLd; pSdo = sdo;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CODE_W-1:0] pat(int p, int s);
    case (p)
      0: return '0;
      1: return '1;
      2: return CODE_W'(12'h001 << (s * 3));
      3: return s[0] ? 12'hAAA : 12'h555;
      4: return CODE_W'(12'h123 + s * 12'h111);
      default: return CODE_W'(12'h800 >> s);
    endcase
  endfunction

  logic [CODE_W-1:0] codes [SLOTS];
  logic [TOT-1:0] prevFrame = '0;

  function automatic logic [TOT-1:0] buildFrame();
    logic [TOT-1:0] f;
    for (int d = 0; d < NUM_DEV; d++)
      f[d*DEVB +: DEVB] = {codes[2*d], codes[2*d+1]};
    return f;
  endfunction

  task automatic wr(input int a, input logic [CODE_W-1:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runXfer(input int hp, input bit midStart, input bit midWrite);
    logic [TOT-1:0] expFrame;
    int guard;
    expFrame = buildFrame();
    halfPeriod = DIV_W'(hp);
    hpExp = (hp == 0) ? 1 : hp;
    @(negedge clk);
    rises = 0; csFalls = 0; dones = 0; phaseErr = 0; sdoErr = 0; csClkErr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    if (midStart || midWrite) begin
      repeat (20) @(negedge clk);
      if (midStart) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
      if (midWrite) wr(0, 12'h5A5);
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done === 1'b1, "R8 done seen", 64'(done), 64'd1);
    @(negedge clk);
    chk(busy === 1'b0, "R8 busy low after done", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk(dones == 1, "R9 single done", 64'(dones), 64'd1);
    chk(csFalls == 1, "R9 single select period", 64'(csFalls), 64'd1);
    chk(rises == TOT, "R3 rising edge count", 64'(rises), 64'(TOT));
    chk(phaseErr == 0, "R6/R7 phase lengths", 64'(phaseErr), 64'd0);
    chk(sdoErr == 0, "R5 sdo stable while sclk high", 64'(sdoErr), 64'd0);
    chk(csClkErr == 0, "R4 clock low at select edges", 64'(csClkErr), 64'd0);
    chk(doneDelay == hpExp, "R8 done delay after load", 64'(doneDelay), 64'(hpExp));
    for (int d = 0; d < NUM_DEV; d++) begin
      chk(dacA[d] == codes[2*d], "R2/R3/R11 device channel A", 64'(dacA[d]), 64'(codes[2*d]));
      chk(dacB[d] == codes[2*d+1], "R2/R3/R11 device channel B", 64'(dacB[d]), 64'(codes[2*d+1]));
    end
    chk(rdData == prevFrame, "R10 readback", 64'(rdData), 64'(prevFrame));
    prevFrame = expFrame;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(csLd === 1'b1, "R1 csLd reset", 64'(csLd), 64'd1);
    chk(sclk === 1'b0, "R1 sclk reset", 64'(sclk), 64'd0);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done reset", 64'({busy, done}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdData === '0, "R1 rdData reset", 64'(rdData), 64'd0);

    for (int hp = 0; hp < 4; hp++) begin
      for (int p = 0; p < 6; p++) begin
        for (int s = 0; s < SLOTS; s++) begin
          codes[s] = pat(p, s);
          wr(s, codes[s]);
        end
        runXfer(hp, 1'b0, 1'b0);
      end
    end

    // R9 and R11: second start and slot write during a transfer
    for (int s = 0; s < SLOTS; s++) begin
      codes[s] = pat(4, s) ^ 12'h0F0;
      wr(s, codes[s]);
    end
    runXfer(2, 1'b1, 1'b1);
    codes[0] = 12'h5A5;
    runXfer(1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule